// File: doc/BRIEF.md
# Byte Serial Peripheral Controller with Completion and Collision Flags

This block moves one byte at a time over a synchronous serial link and is driven by a CPU through a small register port. The port has three registers: control, status and data. When set as master, the block makes the serial clock from the system clock using one of two division ratios. When set as slave, it follows a serial clock that arrives on an input pin. Each transfer shifts eight bits, most significant bit first. The shift register also serves as the data register.

When a transfer ends, a completion flag is set. If interrupts are enabled, this flag raises the interrupt line. A data-register access made while a transfer is running is refused and sets a collision flag. Neither flag can be written. Both are cleared by one two-step sequence: first a status read that sees the completion flag set, then any data-register access. While the completion flag is pending, the shifter is frozen. A data-register access made before the status read is also refused.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero. The outputs irq, sck_o, sck_oe and sdo are low. Register select codes: 0 is control, 1 is status, 2 is data. A read returns its value on reg_rdata one cycle after the read strobe.
- R2: In master mode the master SCK half-period is 1 system clock (SCK = clk/2) when the rate bit is clear and 8 system clocks (SCK = clk/16) when it is set. The first rising SCK edge comes 1 clock (fast) or 8 clocks (slow) after the edge that takes the data write.
- R3: A permitted data write loads the shift register and puts bit 7 on sdo. sdo then moves to the next bit after each falling SCK edge. sdi is shifted into bit 0 on each rising edge. A data read after the transfer returns the received byte.
- R4: The completion flag is status bit 7. It sets on the eighth rising SCK edge, and a master then takes SCK low on the next clock.
- R5: irq is high exactly while both the completion flag and the interrupt-enable bit (control bit 7) are set. irq falls in the cycle the flag clears.
- R6: While the completion flag is set and no status read has seen it, a data access does nothing. A write neither loads nor starts a transfer. A read returns 0x00. The flag stays set.
- R7: A status read that sees the completion flag set, followed by a data access, clears both flags in the same cycle. That finishing access takes effect, so a write there starts a new transfer.
- R8: The collision flag is status bit 6. It sets when the data register is accessed during a transfer. That access is ignored (a read returns 0x00) and the transfer completes with its original data. Collision alone never raises irq.
- R9: In slave mode (control bit 4 clear, enable bit 6 set), sck_oe stays low. Edges on sck_i pass through a two-stage synchroniser and drive the shifter. While the completion flag is pending, further sck_i pulses do not shift.
- R10: Control bits 7, 6, 4 and 0 read back as written. Control bits 5 and 3..1 read zero. Status bits 5..0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable (master and enabled) |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
The completion of a transfer and a colliding data access can land on the same clock edge. This happens when a write arrives in the very cycle of the eighth rising SCK edge, while the transfer still counts as running. The bench times a fast master write to reach that edge exactly. It then expects status 0xC0, meaning both flags were set by that one edge. It also expects the received byte to be unchanged by the refused write. The clearing access and a pending shifter edge are the other pair that can meet. A cycle-accurate behavioural model of the bench compares sck_o, sdo, irq, sck_oe and reg_rdata on every clock across both of these cases.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CB_IE     = 7;
  localparam int CB_EN     = 6;
  localparam int CB_MASTER = 4;
  localparam int CB_RATE   = 0;

  typedef struct packed {
    logic ie;
    logic en;
    logic master;
    logic slow;
  } ctrl_t;
endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic sck,
  output logic rise,
  output logic fall
);
  localparam int HALF_FAST = DIV_FAST / 2;
  localparam int HALF_SLOW = DIV_SLOW / 2;
  localparam int CW = $clog2(HALF_SLOW + 1);

  logic [CW-1:0] cnt_q;
  logic          sck_q;
  logic          tick;

  assign tick = run && (cnt_q == (slow ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1)));
  assign rise = tick & ~sck_q;
  assign fall = tick & sck_q;
  assign sck  = sck_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= sck_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], sck_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rise,
  input  logic         fall,
  input  logic         freeze,
  input  logic         sdi,
  output logic         sdo,
  output logic [W-1:0] shift_val,
  output logic         done,
  output logic         mid
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  logic [W-1:0]  sr_q;
  logic [BW-1:0] bits_q;
  logic          sdo_q;
  logic          step_in;
  logic          step_out;

  assign step_in  = rise & ~freeze;
  assign step_out = fall & ~freeze;
  assign done     = step_in && (bits_q == LAST);
  assign mid      = (bits_q != '0);
  assign sdo      = sdo_q;
  assign shift_val = sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      bits_q <= '0;
      sdo_q  <= 1'b0;
    end else if (load) begin
      sr_q   <= load_val;
      bits_q <= '0;
      sdo_q  <= load_val[W-1];
    end else begin
      if (step_in) begin
        sr_q   <= {sr_q[W-2:0], sdi};
        bits_q <= done ? '0 : bits_q + 1'b1;
      end
      if (step_out) sdo_q <= sr_q[W-1];
    end
  end
endmodule

// File: rtl/spi_status.sv
module spi_status (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic done,
  input  logic in_prog,
  output logic flag,
  output logic coll,
  output logic arm,
  output logic finish
);
  logic flag_q, coll_q, arm_q;
  logic blocked, collide;

  assign blocked = flag_q & ~arm_q;
  assign finish  = data_acc & flag_q & arm_q;
  assign collide = data_acc & ~blocked & in_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      coll_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (done)        flag_q <= 1'b1;
      else if (finish) flag_q <= 1'b0;

      if (collide)     coll_q <= 1'b1;
      else if (finish) coll_q <= 1'b0;

      if (finish)                arm_q <= 1'b0;
      else if (stat_rd & flag_q) arm_q <= 1'b1;
    end
  end

  assign flag = flag_q;
  assign coll = coll_q;
  assign arm  = arm_q;
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_FAST    = 2,
  parameter int DIV_SLOW    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);
  localparam int PAD_W = DATA_W - 2;

  ctrl_t             ctrl_q;
  logic              m_busy_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] shift_q;
  logic              m_rise, m_fall, s_rise, s_fall;
  logic              rise_sel, fall_sel;
  logic              xfer_done, s_mid;
  logic              flag_q, coll_q, arm_q, finish;
  logic              data_acc, stat_rd, in_prog, acc_ok, do_load, start;
  logic              slow_sel;

  assign slow_sel = ctrl_q.slow;
  assign data_acc = (reg_rd | reg_wr) & (reg_sel == SEL_DATA);
  assign stat_rd  = reg_rd & (reg_sel == SEL_STAT);
  assign in_prog  = ctrl_q.master ? m_busy_q : s_mid;
  assign acc_ok   = data_acc & ~(flag_q & ~arm_q) & ~in_prog;
  assign do_load  = acc_ok & reg_wr;
  assign start    = do_load & ctrl_q.master & ctrl_q.en;
  assign rise_sel = ctrl_q.master ? m_rise : (ctrl_q.en & s_rise);
  assign fall_sel = ctrl_q.master ? m_fall : (ctrl_q.en & s_fall);

  spi_clk_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_clk (
    .clk(clk), .rst(rst), .run(m_busy_q), .slow(slow_sel),
    .sck(sck_o), .rise(m_rise), .fall(m_fall)
  );

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_in(sck_i), .rise(s_rise), .fall(s_fall)
  );

  spi_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(do_load), .load_val(reg_wdata),
    .rise(rise_sel), .fall(fall_sel), .freeze(flag_q), .sdi(sdi),
    .sdo(sdo), .shift_val(shift_q), .done(xfer_done), .mid(s_mid)
  );

  spi_status u_stat (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_acc(data_acc),
    .done(xfer_done), .in_prog(in_prog),
    .flag(flag_q), .coll(coll_q), .arm(arm_q), .finish(finish)
  );

  // master transfer runs from the starting write to the last sampling edge
  always_ff @(posedge clk) begin
    if (rst)            m_busy_q <= 1'b0;
    else if (start)     m_busy_q <= 1'b1;
    else if (xfer_done) m_busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (reg_wr && reg_sel == SEL_CTRL) begin
      ctrl_q.ie     <= reg_wdata[CB_IE];
      ctrl_q.en     <= reg_wdata[CB_EN];
      ctrl_q.master <= reg_wdata[CB_MASTER];
      ctrl_q.slow   <= reg_wdata[CB_RATE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      rdata_q <= '0;
      case (reg_sel)
        SEL_CTRL: begin
          rdata_q[CB_IE]     <= ctrl_q.ie;
          rdata_q[CB_EN]     <= ctrl_q.en;
          rdata_q[CB_MASTER] <= ctrl_q.master;
          rdata_q[CB_RATE]   <= ctrl_q.slow;
        end
        SEL_STAT: rdata_q <= {flag_q, coll_q, {PAD_W{1'b0}}};
        SEL_DATA: rdata_q <= acc_ok ? shift_q : '0;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign sck_oe    = ctrl_q.master & ctrl_q.en;
  assign irq       = flag_q & ctrl_q.ie;
endmodule

// File: rtl/spi_flag_chk.sv
module spi_flag_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic              data_acc,
  input logic              done,
  input logic              flag,
  input logic              coll,
  input logic              arm,
  input logic              finish,
  input logic              in_prog,
  input logic              rise_sel,
  input logic [DATA_W-1:0] sr,
  input logic              m_busy,
  input logic              slow,
  input logic              sck_o,
  input logic              irq
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flag && !coll && !irq && !sck_o));

  assert_fast_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (m_busy && $past(m_busy) && !slow && $past(!slow)) |-> (sck_o != $past(sck_o)));

  assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> flag);

  assert_blocked_no_load_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 2'd2 && flag && !arm) |=> $stable(sr));

  assert_finish_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (finish && !in_prog) |=> (!flag && !coll));

  assert_collision_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (data_acc && in_prog && !(flag && !arm)) |=> coll);

  assert_frozen_shift_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && rise_sel && !data_acc) |=> $stable(sr));
endmodule

bind spi_flag_ctrl spi_flag_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .data_acc(data_acc), .done(xfer_done), .flag(flag_q), .coll(coll_q),
  .arm(arm_q), .finish(finish), .in_prog(in_prog), .rise_sel(rise_sel),
  .sr(shift_q), .m_busy(m_busy_q), .slow(slow_sel), .sck_o(sck_o), .irq(irq)
);

// File: tb/test_spi_flag_ctrl.sv
module test_spi_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck_o, sck_oe, sdo, irq;
  logic       sck_i = 1'b0;
  logic       sdi = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  spi_flag_ctrl i_spi_flag_ctrl (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_live = 0;
  bit m_ie, m_en, m_master, m_rate, m_flag, m_coll, m_arm, m_busy, m_sck, m_sdo;
  bit m_s1, m_s2, m_sp;
  int m_cnt, m_bits;
  logic [7:0] m_sr, m_rdata;

  always @(posedge clk) begin
    int half;
    bit tick, mr, mf, rise, fall, acc, blk, fin, inprog, ok, col, done;
    m_live = 1;
    if (rst) begin
      {m_ie, m_en, m_master, m_rate, m_flag, m_coll, m_arm, m_busy, m_sck, m_sdo} = '0;
      {m_s1, m_s2, m_sp} = '0;
      m_cnt = 0; m_bits = 0; m_sr = 8'h00; m_rdata = 8'h00;
    end else begin
      half = m_rate ? 8 : 1;
      tick = m_busy && (m_cnt == half - 1);
      mr = tick && !m_sck;
      mf = tick && m_sck;
      rise = m_master ? mr : (m_en && m_s2 && !m_sp);
      fall = m_master ? mf : (m_en && !m_s2 && m_sp);
      acc = (reg_rd || reg_wr) && reg_sel == 2'd2;
      blk = m_flag && !m_arm;
      fin = acc && m_flag && m_arm;
      inprog = m_master ? m_busy : (m_bits != 0);
      ok = acc && !blk && !inprog;
      col = acc && !blk && inprog;
      done = rise && !m_flag && m_bits == 7;
      if (reg_rd) begin
        case (reg_sel)
          2'd0: m_rdata = {m_ie, m_en, 1'b0, m_master, 3'b000, m_rate};
          2'd1: m_rdata = {m_flag, m_coll, 6'b0};
          2'd2: m_rdata = ok ? m_sr : 8'h00;
          default: m_rdata = 8'h00;
        endcase
      end
      if (m_busy) begin
        if (tick) begin m_cnt = 0; m_sck = !m_sck; end
        else m_cnt++;
      end else begin
        m_cnt = 0; m_sck = 0;
      end
      if (reg_wr && ok) begin
        m_sr = reg_wdata; m_sdo = reg_wdata[7]; m_bits = 0;
      end else begin
        if (fall && !m_flag) m_sdo = m_sr[7];
        if (rise && !m_flag) begin
          m_sr = {m_sr[6:0], sdi};
          m_bits = (m_bits == 7) ? 0 : m_bits + 1;
        end
      end
      if (reg_wr && ok && m_master && m_en) m_busy = 1;
      else if (done) m_busy = 0;
      if (col) m_coll = 1; else if (fin) m_coll = 0;
      if (fin) m_arm = 0; else if (reg_rd && reg_sel == 2'd1 && m_flag) m_arm = 1;
      if (done) m_flag = 1; else if (fin) m_flag = 0;
      m_sp = m_s2; m_s2 = m_s1; m_s1 = sck_i;
      if (reg_wr && reg_sel == 2'd0) begin
        m_ie = reg_wdata[7]; m_en = reg_wdata[6]; m_master = reg_wdata[4]; m_rate = reg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && !done_run) begin
      chk("R2 sck_o vs model", sck_o, m_sck);
      chk("R3 sdo vs model", sdo, m_sdo);
      chk("R5 irq vs model", irq, m_flag && m_ie);
      chk("R9 sck_oe vs model", sck_oe, m_master && m_en);
      chk("R7 reg_rdata vs model", reg_rdata, m_rdata);
    end
  end

  // ---------------- serial data source ----------------
  logic [7:0] pat = 8'h00;
  int  xfer_id = 0, seen_id = 0, pc = 0;
  bit  sck_prev = 0, slave_drv = 0, slv_bit = 0;

  always @(negedge clk) begin
    if (xfer_id != seen_id) begin seen_id = xfer_id; pc = 0; end
    if (sck_o && !sck_prev) pc++;
    sck_prev = sck_o;
    if (slave_drv) sdi = slv_bit;
    else sdi = (pc < 8) ? pat[7-pc] : 1'b0;
  end

  // ---------------- tasks ----------------
  task automatic cpu_write(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int maxc, output int cyc);
    cyc = 0;
    while (!irq && cyc < maxc) begin @(negedge clk); cyc++; end
    if (!irq) chk("R4 completion timeout", 0, 1);
  endtask

  task automatic start_master(input logic [7:0] tx, input logic [7:0] rx);
    pat = rx;
    xfer_id++;
    cpu_write(2'd2, tx);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    done_run = 1;
    summary();
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [7:0] rd;
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 sck_oe", sck_oe, 0);
    chk("R1 sdo", sdo, 0);
    cpu_read(2'd0, rd); chk("R1 ctrl", rd, 8'h00);
    cpu_read(2'd1, rd); chk("R1 status", rd, 8'h00);

    // R10 readback masking
    cpu_write(2'd0, 8'hFF);
    cpu_read(2'd0, rd); chk("R10 ctrl readback", rd, 8'hD1);

    // fast master transfer: R2 R3 R4 R5 R7
    cpu_write(2'd0, 8'hD0);
    start_master(8'hA5, 8'h3C);
    chk("R3 sdo msb first", sdo, 1);
    chk("R2 sck low after write", sck_o, 0);
    @(negedge clk);
    chk("R2 fast first rise", sck_o, 1);
    wait_irq(100, cyc);
    chk("R4 fast completion cycle", cyc, 14);
    chk("R5 irq with flag", irq, 1);
    @(negedge clk);
    chk("R4 sck returns low", sck_o, 0);
    cpu_read(2'd1, rd); chk("R10 status pending", rd, 8'h80);
    chk("R5 irq held until clear", irq, 1);
    cpu_read(2'd2, rd); chk("R3 received byte", rd, 8'h3C);
    chk("R5 irq drops on clear", irq, 0);
    cpu_read(2'd1, rd); chk("R7 flags cleared", rd, 8'h00);

    // R6 blocked access before status read
    start_master(8'h81, 8'hC3);
    wait_irq(100, cyc);
    cpu_read(2'd2, rd); chk("R6 blocked read", rd, 8'h00);
    cpu_write(2'd2, 8'h11);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 blocked write no sck", sck_o, 0);
    end
    cpu_read(2'd1, rd); chk("R6 flag still set", rd, 8'h80);
    cpu_read(2'd2, rd); chk("R6 shift reg kept", rd, 8'hC3);
    cpu_read(2'd1, rd); chk("R7 cleared after sequence", rd, 8'h00);

    // R8 collision on slow transfer, R2 slow rate
    cpu_write(2'd0, 8'hD1);
    start_master(8'h5A, 8'hF0);
    for (int i = 0; i < 7; i++) @(negedge clk);
    chk("R2 slow still low", sck_o, 0);
    @(negedge clk);
    chk("R2 slow first rise", sck_o, 1);
    for (int i = 0; i < 11; i++) @(negedge clk);
    cpu_write(2'd2, 8'h00);
    cpu_read(2'd2, rd); chk("R8 colliding read", rd, 8'h00);
    cpu_read(2'd1, rd); chk("R8 collision flag", rd, 8'h40);
    chk("R8 collision no irq", irq, 0);
    wait_irq(300, cyc);
    cpu_read(2'd1, rd); chk("R8 both flags", rd, 8'hC0);
    cpu_read(2'd2, rd); chk("R8 transfer unaffected", rd, 8'hF0);
    cpu_read(2'd1, rd); chk("R7 both cleared together", rd, 8'h00);

    // R7 finishing write starts a new transfer
    cpu_write(2'd0, 8'hD0);
    start_master(8'h3C, 8'h55);
    wait_irq(100, cyc);
    cpu_read(2'd1, rd); chk("R7 arm read", rd, 8'h80);
    start_master(8'h96, 8'hAA);
    chk("R5 irq low after finish write", irq, 0);
    wait_irq(100, cyc);
    chk("R7 finishing write started transfer", cyc, 15);
    cpu_read(2'd1, rd); chk("R7 second flag", rd, 8'h80);
    cpu_read(2'd2, rd); chk("R3 second receive", rd, 8'hAA);

    // completion and collision on the same edge (R4 R8)
    start_master(8'h0F, 8'h69);
    for (int i = 0; i < 14; i++) @(negedge clk);
    cpu_write(2'd2, 8'hEE);
    chk("R4 flag on eighth edge", irq, 1);
    cpu_read(2'd1, rd); chk("R8 same-edge collision", rd, 8'hC0);
    cpu_read(2'd2, rd); chk("R8 same-edge data", rd, 8'h69);

    // R9 slave mode with ninth pulse ignored
    cpu_write(2'd0, 8'hC0);
    chk("R9 slave sck_oe low", sck_oe, 0);
    cpu_write(2'd2, 8'hE7);
    chk("R3 slave sdo msb", sdo, 1);
    slave_drv = 1;
    pat = 8'h2D;
    for (int i = 0; i < 8; i++) begin
      slv_bit = pat[7-i];
      sck_i = 1'b1;
      repeat (4) @(negedge clk);
      sck_i = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R9 slave completion irq", irq, 1);
    slv_bit = 1'b1;
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
    sck_i = 1'b0;
    repeat (4) @(negedge clk);
    cpu_read(2'd1, rd); chk("R9 slave status", rd, 8'h80);
    cpu_read(2'd2, rd); chk("R9 ninth pulse ignored", rd, 8'h2D);
    cpu_read(2'd1, rd); chk("R7 slave cleared", rd, 8'h00);

    repeat (4) @(negedge clk);
    done_run = 1;
    summary();
    $finish;
  end
endmodule